// File: doc/BRIEF.md
# RMII Receive Dibit Assembler

This block sits behind one port of a reduced media-independent interface, on the receive side, at 100 Mb/s. Each rising edge of the 50 MHz reference clock brings one 2-bit symbol on `rxd` and a level on the shared `crs_dv` line. The block separates that line into two signals. The first is a carrier indication, driven on a port. The second is an internal data-valid qualifier, which stays active while the line alternates as buffered symbols drain after the carrier has gone.

Within a frame, the block skips the zero lead-in and then follows a run of `01` preamble symbols until it sees the `11` delimiter. The symbols after the delimiter are packed into bytes, least significant pair first. The output is a byte stream with a one-clock valid strobe and a start marker on the first byte. The end of the frame is a separate one-clock pulse, which also reports whether a partial byte was left over and thrown away.

The block is placed between the PHY pins and a MAC receive path. It needs no configuration. A synchronous active-low reset returns it to idle.

Top module: `rmii_rx_assembler`

## Requirements
- R1: Inputs are sampled on the rising clock edge. While `rst_n` is low at an edge, `byte_vld`, `byte_eof`, `align_err` and `carrier` are cleared and the frame logic goes idle.
- R2: While no frame is in progress, clocks with `crs_dv` low produce no output event, whatever value `rxd` carries.
- R3: After `crs_dv` rises, leading `00` symbols are skipped. A run of `01` symbols is taken as preamble, and the symbol `11` marks the start of frame data. The delimiter itself is not data.
- R4: A symbol other than `01` or `11` after the preamble has begun, or any symbol other than `00` or `01` as the first non-zero symbol, abandons the frame. No byte or end pulse follows until `crs_dv` has been low for two consecutive clocks.
- R5: Data bytes are packed least significant first. The first symbol after the delimiter becomes bits [1:0], and the fourth becomes bits [7:6]. Each completed byte is presented with `byte_vld` high for one clock.
- R6: `byte_sof` is high together with `byte_vld` on the first byte of a frame, and low on every other byte.
- R7: Within frame data, a clock with `crs_dv` low that is followed by a clock with `crs_dv` high still carries a data symbol, which is accepted. Values on `rxd` during such low clocks are data.
- R8: Two consecutive clocks with `crs_dv` low end the frame. This gives one `byte_eof` pulse, with `byte_vld` low in that clock and in the clock after it.
- R9: If the number of data symbols in a frame is not a multiple of four, the partial byte is dropped, and `align_err` is high together with `byte_eof`. Otherwise `align_err` stays low.
- R10: `carrier` is set by any clock with `crs_dv` high. Outside frame data, it is cleared by any clock with `crs_dv` low. Within frame data, and through the two closing low clocks, it is cleared only by a low clock that falls on the first symbol of a nibble, counted from the first data symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| crs_dv | input | 1 | Shared carrier / data-valid line from the PHY |
| rxd | input | 2 | Receive symbol bus |
| byte_data | output | 8 | Assembled data byte |
| byte_vld | output | 1 | One-clock strobe: `byte_data` holds a new byte |
| byte_sof | output | 1 | First byte of the frame, qualified by `byte_vld` |
| byte_eof | output | 1 | One-clock end-of-frame pulse |
| align_err | output | 1 | Partial byte dropped, qualified by `byte_eof` |
| carrier | output | 1 | Recovered carrier presence |

## Verification
The assertions assume that `crs_dv` never stays low for two clocks in a row in the middle of frame data. They also assume that the alternating drain pattern starts only on a nibble boundary and ends on the second symbol of a nibble, so that a single low clock always means drained data and not an end of frame. The stimulus keeps to these limits. The preamble always has an odd number of `01` symbols, so the delimiter lands on the second symbol of its nibble. The drain pattern is used only when the data symbol count is even, and it always begins at an even data index. Frames that end on a partial byte with an odd symbol count hold `crs_dv` high up to their last symbol.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_PRE,
    ST_DATA,
    ST_DROP
  } rx_state_t;

  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [1:0] SYM_PRE  = 2'b01;
  localparam logic [1:0] SYM_SFD  = 2'b11;

  // Classify the first non-zero symbol seen before the preamble.
  function automatic rx_state_t lead_next(input logic [1:0] sym);
    rx_state_t r;
    if (sym == SYM_ZERO)     r = ST_LEAD;
    else if (sym == SYM_PRE) r = ST_PRE;
    else                     r = ST_DROP;
    return r;
  endfunction

  // A delayed symbol is live if its own strobe or the next one is high.
  function automatic logic sym_live(input logic v_prev, input logic v_now);
    return v_prev | v_now;
  endfunction

endpackage

// File: rtl/rmii_rx_front.sv
module rmii_rx_front #(
  parameter int SYM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             crs_dv,
  input  logic [SYM_W-1:0] rxd,
  output logic             v_q,
  output logic [SYM_W-1:0] x_q
);
  // One-symbol delay so each symbol is judged with the following strobe.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      x_q <= '0;
    end else begin
      v_q <= crs_dv;
      x_q <= rxd;
    end
  end
endmodule

// File: rtl/rmii_rx_fsm.sv
module rmii_rx_fsm
  import rmii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       v_q,
  input  logic [1:0] x_q,
  input  logic       v_now,
  output logic       in_data,
  output logic       take,
  output logic       frame_start,
  output logic       frame_end
);
  rx_state_t st, nxt;
  logic      live, gone;

  assign live = sym_live(v_q, v_now);
  assign gone = !v_q && !v_now;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE: if (v_q) nxt = lead_next(x_q);
      ST_LEAD: begin
        if (gone)      nxt = ST_IDLE;
        else if (live) nxt = lead_next(x_q);
      end
      ST_PRE: begin
        if (gone) nxt = ST_IDLE;
        else if (live) begin
          if (x_q == SYM_SFD)      nxt = ST_DATA;
          else if (x_q != SYM_PRE) nxt = ST_DROP;
        end
      end
      ST_DATA: if (gone) nxt = ST_IDLE;
      ST_DROP: if (gone) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  assign in_data     = (st == ST_DATA);
  assign take        = in_data && live;
  assign frame_end   = in_data && gone;
  assign frame_start = (st == ST_PRE) && live && (x_q == SYM_SFD);
endmodule

// File: rtl/rmii_rx_packer.sv
module rmii_rx_packer #(
  parameter int BYTE_W = 8,
  parameter int SYM_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [SYM_W-1:0]  x_q,
  input  logic              frame_start,
  input  logic              frame_end,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_vld,
  output logic              byte_sof,
  output logic              byte_eof,
  output logic              align_err,
  output logic              ph_odd
);
  localparam int SYMS = BYTE_W / SYM_W;
  localparam int CW   = (SYMS > 1) ? $clog2(SYMS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SYMS - 1);

  logic [BYTE_W-1:0] sh;
  logic [CW-1:0]     cnt;
  logic              first_pend;
  logic [BYTE_W-1:0] sh_next;

  // New symbol enters at the top; the oldest ends up in the low bits.
  function automatic logic [BYTE_W-1:0] push_sym(input logic [BYTE_W-1:0] cur,
                                                  input logic [SYM_W-1:0] s);
    return {s, cur[BYTE_W-1:SYM_W]};
  endfunction

  assign sh_next = push_sym(sh, x_q);
  assign ph_odd  = cnt[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh         <= '0;
      cnt        <= '0;
      first_pend <= 1'b0;
      byte_data  <= '0;
      byte_vld   <= 1'b0;
      byte_sof   <= 1'b0;
      byte_eof   <= 1'b0;
      align_err  <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      byte_sof  <= 1'b0;
      byte_eof  <= 1'b0;
      align_err <= 1'b0;
      if (frame_start) begin
        cnt        <= '0;
        first_pend <= 1'b1;
      end else if (take) begin
        sh <= sh_next;
        if (cnt == LAST) begin
          cnt        <= '0;
          byte_data  <= sh_next;
          byte_vld   <= 1'b1;
          byte_sof   <= first_pend;
          first_pend <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (frame_end) begin
        byte_eof   <= 1'b1;
        align_err  <= (cnt != '0);
        first_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rmii_rx_carrier.sv
module rmii_rx_carrier (
  input  logic clk,
  input  logic rst_n,
  input  logic crs_dv,
  input  logic in_data,
  input  logic ph_odd,
  output logic carrier
);
  logic nib_head;

  // The raw symbol opens a nibble unless it is the partner of an even one.
  assign nib_head = !in_data || ph_odd;

  always_ff @(posedge clk) begin
    if (!rst_n)        carrier <= 1'b0;
    else if (crs_dv)   carrier <= 1'b1;
    else if (nib_head) carrier <= 1'b0;
  end
endmodule

// File: rtl/rmii_rx_assembler.sv
module rmii_rx_assembler #(
  parameter int BYTE_W = 8,
  parameter int SYM_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crs_dv,
  input  logic [SYM_W-1:0]  rxd,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_vld,
  output logic              byte_sof,
  output logic              byte_eof,
  output logic              align_err,
  output logic              carrier
);
  logic             v_q;
  logic [SYM_W-1:0] x_q;
  logic             in_data;
  logic             dibit_take;
  logic             sfd_seen;
  logic             end_seen;
  logic             ph_odd;

  rmii_rx_front #(.SYM_W(SYM_W)) u_front (
    .clk(clk), .rst_n(rst_n), .crs_dv(crs_dv), .rxd(rxd),
    .v_q(v_q), .x_q(x_q)
  );

  rmii_rx_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .v_q(v_q), .x_q(x_q), .v_now(crs_dv),
    .in_data(in_data), .take(dibit_take), .frame_start(sfd_seen),
    .frame_end(end_seen)
  );

  rmii_rx_packer #(.BYTE_W(BYTE_W), .SYM_W(SYM_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(dibit_take), .x_q(x_q),
    .frame_start(sfd_seen), .frame_end(end_seen),
    .byte_data(byte_data), .byte_vld(byte_vld), .byte_sof(byte_sof),
    .byte_eof(byte_eof), .align_err(align_err), .ph_odd(ph_odd)
  );

  rmii_rx_carrier u_car (
    .clk(clk), .rst_n(rst_n), .crs_dv(crs_dv), .in_data(in_data),
    .ph_odd(ph_odd), .carrier(carrier)
  );
endmodule

// File: rtl/rmii_rx_checker.sv
module rmii_rx_checker (
  input logic clk,
  input logic rst_n,
  input logic crs_dv,
  input logic byte_vld,
  input logic byte_sof,
  input logic byte_eof,
  input logic align_err,
  input logic carrier,
  input logic dibit_take
);
  // R5
  byte_from_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(dibit_take));

  // R6
  sof_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sof |-> byte_vld);

  // R8
  eof_two_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_eof |-> (!$past(crs_dv) && !$past(crs_dv, 2)));

  // R8
  eof_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_eof |-> !byte_vld);

  // R8
  eof_quiet_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_eof |=> !byte_vld);

  // R9
  align_with_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> byte_eof);

  // R10
  carrier_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier) |-> $past(crs_dv));
endmodule

bind rmii_rx_assembler rmii_rx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .crs_dv(crs_dv), .byte_vld(byte_vld),
  .byte_sof(byte_sof), .byte_eof(byte_eof), .align_err(align_err),
  .carrier(carrier), .dibit_take(dibit_take)
);

// File: tb/sim_rmii_rx_assembler.sv
module sim_rmii_rx_assembler;
  localparam int CLK_PERIOD = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       crs_dv = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic [7:0] byte_data;
  logic       byte_vld, byte_sof, byte_eof, align_err, carrier;

  int checks = 0;
  int errors = 0;
  logic exp_car = 1'b0;
  logic [10:0] expq[$];
  logic [10:0] actq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rmii_rx_assembler u0 (
    .clk(clk), .rst_n(rst_n), .crs_dv(crs_dv), .rxd(rxd),
    .byte_data(byte_data), .byte_vld(byte_vld), .byte_sof(byte_sof),
    .byte_eof(byte_eof), .align_err(align_err), .carrier(carrier)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Event word: {eof, align, sof, data}
  function automatic logic [10:0] byte_evt(input logic sof, input logic [7:0] d);
    return {1'b0, 1'b0, sof, d};
  endfunction
  function automatic logic [10:0] end_evt(input int nsym);
    return {1'b1, (nsym % 4) != 0, 1'b0, 8'h00};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_vld) actq.push_back({1'b0, 1'b0, byte_sof, byte_data});
      if (byte_eof) actq.push_back({1'b1, align_err, 1'b0, 8'h00});
    end
  end

  // One clock of stimulus; head marks a symbol that opens a nibble (R10 model).
  task automatic drive(input logic v, input logic [1:0] x, input logic head);
    @(negedge clk);
    chk(carrier === exp_car, "R10 carrier", carrier, exp_car);
    crs_dv = v;
    rxd = x;
    @(posedge clk);
    if (v)         exp_car = 1'b1;
    else if (head) exp_car = 1'b0;
  endtask

  task automatic compare(input string tag);
    chk(actq.size() == expq.size(), {tag, " R3 event count"}, actq.size(), expq.size());
    if (actq.size() == expq.size()) begin
      for (int i = 0; i < expq.size(); i++) begin
        if (expq[i][10])
          chk(actq[i] === expq[i], {tag, " R8 R9 end event"}, actq[i], expq[i]);
        else
          chk(actq[i] === expq[i], {tag, " R5 R6 byte"}, actq[i], expq[i]);
      end
    end
    actq.delete();
    expq.delete();
  endtask

  task automatic send_frame(input int lead, input int npre, input int nbytes,
                            input int extra, input bit toggle, input bit bad,
                            input bit nosfd);
    logic [1:0] sym[$];
    int nsym, j;
    bit live_frame;
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] d = 8'($urandom);
      for (int k = 0; k < 4; k++) sym.push_back(d[2*k +: 2]);
      if (!bad && !nosfd) expq.push_back(byte_evt(b == 0, d));
    end
    for (int k = 0; k < extra; k++) sym.push_back(2'($urandom));
    nsym = sym.size();
    live_frame = !bad && !nosfd;
    if (live_frame) expq.push_back(end_evt(nsym));
    j = nsym;
    if (toggle && (nsym % 2 == 0) && nsym > 0) j = 2 * int'($urandom % (nsym/2 + 1));
    for (int i = 0; i < lead; i++) drive(1'b1, 2'b00, 1'b1);
    for (int i = 0; i < npre; i++)
      drive(1'b1, (bad && i == npre/2) ? 2'b10 : 2'b01, 1'b1);
    if (!nosfd) begin
      drive(1'b1, 2'b11, 1'b1);
      for (int i = 0; i < nsym; i++)
        drive((i < j) ? 1'b1 : (i % 2 == 1), sym[i], bad ? 1'b1 : (i % 2 == 0));
    end
    drive(1'b0, 2'($urandom), live_frame ? (nsym % 2 == 0) : 1'b1);
    drive(1'b0, 2'($urandom), live_frame ? (nsym % 2 == 1) : 1'b1);
    for (int i = 0; i < 3 + int'($urandom % 4); i++) drive(1'b0, 2'($urandom), 1'b1);
    if (bad)        compare("R4 bad preamble");
    else if (nosfd) compare("R3 no delimiter");
    else if (j < nsym) compare("R7 drain toggle");
    else            compare("frame");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs clear under reset
    chk({byte_vld, byte_eof, align_err, carrier} == 4'b0, "R1 reset state",
        {byte_vld, byte_eof, align_err, carrier}, 0);
    rst_n = 1'b1;

    // R2: idle garbage with crs_dv low
    for (int i = 0; i < 12; i++) drive(1'b0, 2'($urandom), 1'b1);
    compare("R2 idle garbage");

    // Directed corners
    send_frame(0, 1, 1, 0, 0, 0, 0);   // R3 no lead-in, shortest preamble
    send_frame(5, 7, 3, 0, 1, 0, 0);   // R7 drain
    send_frame(2, 5, 0, 0, 0, 0, 0);   // R9 empty frame, no error
    send_frame(1, 5, 2, 1, 0, 0, 0);   // R9 one spare symbol
    send_frame(1, 5, 2, 3, 0, 0, 0);   // R9 three spare symbols
    send_frame(1, 5, 2, 2, 1, 0, 0);   // R7 R9 drain with partial
    send_frame(3, 9, 4, 0, 0, 1, 0);   // R4 bad symbol in preamble
    send_frame(3, 9, 0, 0, 0, 0, 1);   // R3 preamble without delimiter

    // Constrained random frames
    for (int f = 0; f < 40; f++) begin
      int r = int'($urandom % 10);
      send_frame(int'($urandom % 6), 2 * int'($urandom % 14) + 1,
                 int'($urandom % 16), int'($urandom % 4),
                 ($urandom % 2) == 1, r == 0, r == 1);
    end

    // R1: reset mid-frame returns to idle and clears outputs
    drive(1'b1, 2'b01, 1'b1);
    drive(1'b1, 2'b11, 1'b1);
    drive(1'b1, 2'b10, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    crs_dv = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk({byte_vld, byte_eof, carrier} == 3'b0, "R1 reset mid-frame",
        {byte_vld, byte_eof, carrier}, 0);
    rst_n = 1'b1;
    exp_car = 1'b0;
    actq.delete();
    for (int i = 0; i < 6; i++) drive(1'b0, 2'b11, 1'b1);
    compare("R1 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule